// File: doc/BRIEF.md
# Packed Four-Pixel Half-Sample Interpolator

This block forms motion-compensated prediction pixels four at a time. Each pixel is one byte lane of a 32-bit word. Reference rows arrive as pairs of word-aligned fetches. A 2-bit byte offset gives the horizontal position inside the lower word. The block realigns the bytes it needs from each row pair. It then produces one of four results per lane: a plain copy, a horizontal two-point average, a vertical two-point average, or a four-point average of a 2x2 neighbourhood. A rounding-control bit lowers the rounding bias by one.

All averaging runs on the packed word. Each operand is split into a high part and a low part and masked per lane, so no carry ever crosses a byte boundary. The block is pipelined in two register stages. Stage one holds the realigned operands. Stage two holds the packed result. Address generation and frame-memory access lie outside the block.

Top module: `quadpel_interp`

## Requirements
- R1: When `rst` is high at a rising clock edge, `out_valid` is 0 and `out_pix` is 0 after that edge.
- R2: `out_valid` after rising edge k equals `in_valid` at edge k-1, so each accepted beat appears two edges after it is presented. Beats come out in the order they went in.
- R3: With mode 0 (copy) and offset 0, `out_pix` equals `in_row0_lo` exactly.
- R4: The row-0 window W0 is `{in_row0_hi, in_row0_lo}`, with its bytes numbered from 0 at bit 0 upward. In copy mode, output lane i (bits 8i+7:8i) equals W0 byte (offset+i).
- R5: Mode 1 (horizontal): lane i equals (W0[o+i] + W0[o+i+1] + 1 - rc) / 2, rounded down.
- R6: Mode 2 (vertical): lane i equals (W0[o+i] + W1[o+i] + 1 - rc) / 2, rounded down. W1 is `{in_row1_hi, in_row1_lo}`, numbered the same way.
- R7: Mode 3 (four-point): lane i equals (W0[o+i] + W0[o+i+1] + W1[o+i] + W1[o+i+1] + 2 - rc) / 4, rounded down.
- R8: On a cycle with no beat, the data inputs are ignored and `out_pix` keeps its last value.
- R9: Lanes are independent. All-255 operands give 255 in every lane, and alternating 0/255 bytes give exact per-lane results in every mode and for both rc values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A beat is presented this cycle |
| in_row0_lo | input | 32 | Row 0, lower aligned word |
| in_row0_hi | input | 32 | Row 0, next aligned word |
| in_row1_lo | input | 32 | Row 1, lower aligned word |
| in_row1_hi | input | 32 | Row 1, next aligned word |
| in_offset | input | 2 | Byte offset of the first pixel in the lower word |
| in_mode | input | 2 | 0 copy, 1 horizontal, 2 vertical, 3 four-point |
| in_rc | input | 1 | Rounding control (1 lowers the rounding bias) |
| out_valid | output | 1 | `out_pix` carries a new result |
| out_pix | output | 32 | Four packed prediction pixels, lane 0 in bits 7:0 |

## Verification
The bench builds the block with its default package values: four lanes of eight bits. With these values every offset from 0 to 3 can be reached. At offset 3, the horizontal and four-point modes read the top byte of the window, so the last lane has to take its neighbour from the upper aligned word. Every combination of offset, mode and rc is driven with random bytes and with saturating patterns. Idle gaps between beats carry random data, which exposes any leak into the held output.

// File: rtl/quadpel_pkg.sv
package quadpel_pkg;

    // Lane geometry
    localparam int LANES  = 4;
    localparam int PIX_W  = 8;
    localparam int WORD_W = LANES * PIX_W;
    localparam int WIN_W  = 2 * WORD_W;
    localparam int OFF_W  = $clog2(LANES);
    localparam int SEL_W  = $clog2(2 * LANES);
    localparam int ROWS   = 2;

    typedef enum logic [1:0] {
        MODE_COPY = 2'd0,
        MODE_HORZ = 2'd1,
        MODE_VERT = 2'd2,
        MODE_QUAD = 2'd3
    } interp_mode_e;

    typedef logic [WORD_W-1:0] pword_t;

    typedef struct packed {
        logic         valid;
        interp_mode_e mode;
        logic         rc;
        pword_t       a;   // row 0, position x
        pword_t       b;   // row 0, position x+1
        pword_t       c;   // row 1, position x
        pword_t       d;   // row 1, position x+1
    } op_stage_t;

    // Replicate one lane pattern across the packed word
    function automatic pword_t lane_rep(input logic [PIX_W-1:0] pat);
        pword_t r;
        r = '0;
        for (int ln = 0; ln < LANES; ln++) begin
            r[ln*PIX_W +: PIX_W] = pat;
        end
        return r;
    endfunction

    localparam logic [PIX_W-1:0] PAT_LSB1  = PIX_W'(1);
    localparam logic [PIX_W-1:0] PAT_LSB2  = PIX_W'(3);
    localparam logic [PIX_W-1:0] PAT_TOP7  = {1'b0, {(PIX_W-1){1'b1}}};
    localparam logic [PIX_W-1:0] PAT_TOP6  = {2'b00, {(PIX_W-2){1'b1}}};

    localparam pword_t MASK_LSB1 = lane_rep(PAT_LSB1);
    localparam pword_t MASK_LSB2 = lane_rep(PAT_LSB2);
    localparam pword_t MASK_SH1  = lane_rep(PAT_TOP7);
    localparam pword_t MASK_SH2  = lane_rep(PAT_TOP6);

    // Select one pixel out of a two-word window
    function automatic logic [PIX_W-1:0] pick_pix(input logic [WIN_W-1:0] win,
                                                  input logic [SEL_W-1:0] idx);
        logic [PIX_W-1:0] r;
        r = '0;
        for (int j = 0; j < 2 * LANES; j++) begin
            if (SEL_W'(j) == idx) begin
                r = win[j*PIX_W +: PIX_W];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/quadpel_align.sv
module quadpel_align
    import quadpel_pkg::*;
(
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    input  logic [OFF_W-1:0]  offset,
    output logic [WORD_W-1:0] cur,
    output logic [WORD_W-1:0] nxt
);

    logic [WIN_W-1:0] win;
    assign win = {hi, lo};

    // Little-endian byte pick: lane i takes window byte offset+i (and +1)
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [SEL_W-1:0] idx_cur;
        logic [SEL_W-1:0] idx_nxt;

        assign idx_cur = SEL_W'(offset) + SEL_W'(ln);
        assign idx_nxt = idx_cur + SEL_W'(1);

        assign cur[ln*PIX_W +: PIX_W] = pick_pix(win, idx_cur);
        assign nxt[ln*PIX_W +: PIX_W] = pick_pix(win, idx_nxt);
    end

endmodule

// File: rtl/quadpel_avg2.sv
module quadpel_avg2
    import quadpel_pkg::*;
(
    input  pword_t a,
    input  pword_t b,
    input  logic   rc,
    output pword_t y
);

    pword_t half_a;
    pword_t half_b;
    pword_t carry_in;

    // Halve each lane without letting bits fall into the lane below
    assign half_a = (a >> 1) & MASK_SH1;
    assign half_b = (b >> 1) & MASK_SH1;

    // Rounding bit from the discarded LSBs: OR rounds up ties, AND rounds down
    assign carry_in = rc ? (a & b & MASK_LSB1) : ((a | b) & MASK_LSB1);

    // Each lane sum stays at or below the lane maximum, so no carry escapes
    assign y = half_a + half_b + carry_in;

endmodule

// File: rtl/quadpel_avg4.sv
module quadpel_avg4
    import quadpel_pkg::*;
(
    input  pword_t a,
    input  pword_t b,
    input  pword_t c,
    input  pword_t d,
    input  logic   rc,
    output pword_t y
);

    pword_t upper_sum;
    pword_t lower_sum;
    pword_t bias;

    // Upper bits, pre-divided by four; each lane peaks at 4 * max/4
    assign upper_sum = ((a >> 2) & MASK_SH2) + ((b >> 2) & MASK_SH2)
                     + ((c >> 2) & MASK_SH2) + ((d >> 2) & MASK_SH2);

    // Rounding bias is 2 - rc per lane
    assign bias = rc ? MASK_LSB1 : (MASK_LSB1 << 1);

    // Two LSBs of each operand plus bias; per lane at most 4*3+2 = 14
    assign lower_sum = (a & MASK_LSB2) + (b & MASK_LSB2)
                     + (c & MASK_LSB2) + (d & MASK_LSB2) + bias;

    // Quarter of the low part joins the high part; bits shifted in from above are masked
    assign y = upper_sum + ((lower_sum >> 2) & MASK_LSB2);

endmodule

// File: rtl/quadpel_interp.sv
module quadpel_interp
    import quadpel_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_row0_lo,
    input  logic [31:0] in_row0_hi,
    input  logic [31:0] in_row1_lo,
    input  logic [31:0] in_row1_hi,
    input  logic [1:0]  in_offset,
    input  logic [1:0]  in_mode,
    input  logic        in_rc,
    output logic        out_valid,
    output logic [31:0] out_pix
);

    pword_t row_lo  [ROWS];
    pword_t row_hi  [ROWS];
    pword_t row_cur [ROWS];
    pword_t row_nxt [ROWS];

    assign row_lo[0] = in_row0_lo;
    assign row_hi[0] = in_row0_hi;
    assign row_lo[1] = in_row1_lo;
    assign row_hi[1] = in_row1_hi;

    // Stage 1: realign each row pair
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        quadpel_align u_align (
            .lo     (row_lo[r]),
            .hi     (row_hi[r]),
            .offset (in_offset),
            .cur    (row_cur[r]),
            .nxt    (row_nxt[r])
        );
    end

    op_stage_t ops_d;
    op_stage_t ops_q;

    always_comb begin
        ops_d.valid = in_valid;
        ops_d.mode  = interp_mode_e'(in_mode);
        ops_d.rc    = in_rc;
        ops_d.a     = row_cur[0];
        ops_d.b     = row_nxt[0];
        ops_d.c     = row_cur[1];
        ops_d.d     = row_nxt[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ops_q <= '0;
        end else begin
            ops_q <= ops_d;
        end
    end

    // Stage 2: lane-safe averaging
    pword_t horz_y;
    pword_t vert_y;
    pword_t quad_y;
    pword_t result;

    quadpel_avg2 u_horz (
        .a  (ops_q.a),
        .b  (ops_q.b),
        .rc (ops_q.rc),
        .y  (horz_y)
    );

    quadpel_avg2 u_vert (
        .a  (ops_q.a),
        .b  (ops_q.c),
        .rc (ops_q.rc),
        .y  (vert_y)
    );

    quadpel_avg4 u_quad (
        .a  (ops_q.a),
        .b  (ops_q.b),
        .c  (ops_q.c),
        .d  (ops_q.d),
        .rc (ops_q.rc),
        .y  (quad_y)
    );

    always_comb begin
        unique case (ops_q.mode)
            MODE_COPY: result = ops_q.a;
            MODE_HORZ: result = horz_y;
            MODE_VERT: result = vert_y;
            MODE_QUAD: result = quad_y;
            default:   result = ops_q.a;
        endcase
    end

    logic   vld_q;
    pword_t pix_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            pix_q <= '0;
        end else begin
            vld_q <= ops_q.valid;
            if (ops_q.valid) begin
                pix_q <= result;
            end
        end
    end

    assign out_valid = vld_q;
    assign out_pix   = pix_q;

endmodule

// File: rtl/quadpel_interp_chk.sv
module quadpel_interp_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_row0_lo,
    input logic [1:0]  in_offset,
    input logic [1:0]  in_mode,
    input logic        out_valid,
    input logic [31:0] out_pix
);

    // Edges seen since reset, saturating at the pipeline depth
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= 2'd0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    // R1: reset empties the output
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_pix == 32'd0));

    // R2: fixed two-edge latency
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R3: aligned copy is the lower word itself
    a_r3_aligned_copy: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && out_valid && $past(in_valid, 2)
         && $past(in_mode, 2) == 2'd0 && $past(in_offset, 2) == 2'd0)
        |-> (out_pix == $past(in_row0_lo, 2)));

    // R8: no beat, no change
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && !$past(in_valid, 2)) |-> $stable(out_pix));

endmodule

bind quadpel_interp quadpel_interp_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_row0_lo (in_row0_lo),
    .in_offset  (in_offset),
    .in_mode    (in_mode),
    .out_valid  (out_valid),
    .out_pix    (out_pix)
);

// File: tb/test_quadpel_interp.sv
module test_quadpel_interp;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_row0_lo = '0;
    logic [31:0] in_row0_hi = '0;
    logic [31:0] in_row1_lo = '0;
    logic [31:0] in_row1_hi = '0;
    logic [1:0]  in_offset = '0;
    logic [1:0]  in_mode = '0;
    logic        in_rc = 1'b0;
    logic        out_valid;
    logic [31:0] out_pix;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_P/2) clk = ~clk;

    quadpel_interp i_quadpel_interp (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_row0_lo (in_row0_lo),
        .in_row0_hi (in_row0_hi),
        .in_row1_lo (in_row1_lo),
        .in_row1_hi (in_row1_hi),
        .in_offset  (in_offset),
        .in_mode    (in_mode),
        .in_rc      (in_rc),
        .out_valid  (out_valid),
        .out_pix    (out_pix)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Scalar reference built from the requirement formulas
    function automatic logic [31:0] model(input logic [31:0] lo0, input logic [31:0] hi0,
                                          input logic [31:0] lo1, input logic [31:0] hi1,
                                          input int off, input int mode, input int rc);
        logic [63:0] w0;
        logic [63:0] w1;
        logic [31:0] r;
        w0 = {hi0, lo0};
        w1 = {hi1, lo1};
        r  = '0;
        for (int i = 0; i < 4; i++) begin
            int p, q, s, t, v;
            p = int'(w0[8*(off+i) +: 8]);
            q = int'(w0[8*(off+i+1) +: 8]);
            s = int'(w1[8*(off+i) +: 8]);
            t = int'(w1[8*(off+i+1) +: 8]);
            case (mode)
                0:       v = p;
                1:       v = (p + q + 1 - rc) / 2;
                2:       v = (p + s + 1 - rc) / 2;
                default: v = (p + q + s + t + 2 - rc) / 4;
            endcase
            r[8*i +: 8] = 8'(v);
        end
        return r;
    endfunction

    function automatic string tag_of(input int off, input int mode);
        case (mode)
            0:       return (off == 0) ? "R3" : "R4";
            1:       return "R5";
            2:       return "R6";
            default: return "R7";
        endcase
    endfunction

    // Driver: present one beat and record its expected result
    task automatic drive(input logic [31:0] lo0, input logic [31:0] hi0,
                         input logic [31:0] lo1, input logic [31:0] hi1,
                         input int off, input int mode, input int rc, input string tg);
        @(negedge clk);
        in_valid   = 1'b1;
        in_row0_lo = lo0;
        in_row0_hi = hi0;
        in_row1_lo = lo1;
        in_row1_hi = hi1;
        in_offset  = 2'(off);
        in_mode    = 2'(mode);
        in_rc      = 1'(rc);
        exp_q.push_back(model(lo0, hi0, lo1, hi1, off, mode, rc));
        tag_q.push_back(tg);
    endtask

    // Idle cycles carry random data that must be ignored (R8)
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid   = 1'b0;
            in_row0_lo = $urandom;
            in_row0_hi = $urandom;
            in_row1_lo = $urandom;
            in_row1_hi = $urandom;
            in_offset  = 2'($urandom);
            in_mode    = 2'($urandom);
            in_rc      = 1'($urandom);
        end
    endtask

    // Monitor: scoreboard pop, latency and hold checks
    logic        prev_in  = 1'b0;
    logic [31:0] last_out = '0;

    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst) begin
            prev_in  = 1'b0;
            last_out = '0;
        end else begin
            check("R2", {31'd0, out_valid}, {31'd0, prev_in});
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2", 32'd1, 32'd0);
                end else begin
                    logic [31:0] e;
                    string       tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    check(tg, out_pix, e);
                end
            end else begin
                check("R8", out_pix, last_out);
            end
            last_out = out_pix;
            prev_in  = in_valid;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check("R1", {31'd0, out_valid}, 32'd0);
        check("R1", out_pix, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R3: aligned copy
        drive(32'hDEADBEEF, 32'h01234567, 32'h0, 32'h0, 0, 0, 0, "R3");
        // R4: each offset in copy mode, byte order visible
        for (int o = 1; o < 4; o++) begin
            drive(32'h33221100, 32'h77665544, 32'h0, 32'h0, o, 0, 0, "R4");
        end
        idle(3);

        // R9: saturated and alternating lanes, every mode and rc
        for (int m = 0; m < 4; m++) begin
            for (int rc = 0; rc < 2; rc++) begin
                for (int o = 0; o < 4; o++) begin
                    drive(32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, o, m, rc, "R9");
                    drive(32'h00FF00FF, 32'hFF00FF00, 32'hFF00FF00, 32'h00FF00FF, o, m, rc, "R9");
                    drive(32'h01010101, 32'h00000000, 32'h00000000, 32'h01010101, o, m, rc, "R9");
                end
            end
        end
        idle(2);

        // R5-R7 and offsets: random bytes across all combinations
        for (int m = 0; m < 4; m++) begin
            for (int rc = 0; rc < 2; rc++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int k = 0; k < 40; k++) begin
                        drive($urandom, $urandom, $urandom, $urandom, o, m, rc, tag_of(o, m));
                        if (($urandom % 4) == 0) idle(1 + ($urandom % 2));
                    end
                end
            end
        end

        idle(6);
        // R2: every beat came out
        check("R2", exp_q.size(), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule